// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block decides, for the instruction sitting in the execute stage of a five-stage in-order integer pipeline, where each of the two ALU operands should come from. An operand can come from the value read out of the register file, from the result held in the execute/memory pipeline register, or from the result held in the memory/writeback pipeline register. The block compares the two source register numbers of the execute-stage instruction against the destination register numbers of the two older instructions still in flight. It drives one 2-bit select per operand to the datapath muxes.

The logic is purely combinational and holds no state, so it has no clock or reset. When both older stages target the register an operand needs, the younger result in execute/memory is chosen. Register zero is hard-wired and is never forwarded. Stall generation, the muxes themselves and the register file belong to neighbouring blocks.

Top module: `fwd_unit`

## Requirements
- R1: With no write enable and no register match in either stage, both selects are 2'b00 (register-file value).
- R2: `sel_a` is 2'b10 when `mem_wr_en` is 1, `mem_dst_idx` is nonzero and `mem_dst_idx` equals `ex_src_a_idx`.
- R3: `sel_b` is 2'b10 when `mem_wr_en` is 1, `mem_dst_idx` is nonzero and `mem_dst_idx` equals `ex_src_b_idx`.
- R4: An operand's select is 2'b01 when `wb_wr_en` is 1, `wb_dst_idx` is nonzero and equals that operand's source index, and the execute/memory stage does not match that operand.
- R5: When both stages would forward to the same operand, the select is 2'b10, the execute/memory result.
- R6: A destination of register 0 never causes forwarding; a source index of 0 always gives select 2'b00.
- R7: A stage whose write enable is 0 never causes forwarding, whatever its destination index.
- R8: Neither select ever takes the value 2'b11.
- R9: The two operands are resolved independently: they may take different selects at the same time, and both take the same forwarding select when both source indices name the same register.
- R10: The selects follow the inputs combinationally, with no cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_a_idx | input | 5 | First source register number of the execute-stage instruction |
| ex_src_b_idx | input | 5 | Second source register number of the execute-stage instruction |
| mem_dst_idx | input | 5 | Destination register number in the execute/memory register |
| mem_wr_en | input | 1 | Execute/memory instruction writes the register file |
| wb_dst_idx | input | 5 | Destination register number in the memory/writeback register |
| wb_wr_en | input | 1 | Memory/writeback instruction writes the register file |
| sel_a | output | 2 | Operand A source: 00 register file, 10 execute/memory, 01 memory/writeback |
| sel_b | output | 2 | Operand B source, same encoding as `sel_a` |

## Verification
The bound checker watches, whenever the inputs are known, that no select is ever 2'b11, that a zero source index or two disabled stages leave both selects at the register-file code, and that an execute/memory match always wins while a lone memory/writeback match gives 2'b01. What these properties cannot show is that the right cases are actually reached: the bench drives single-stage dependences on each operand, double dependences on the same register, register-zero destinations with write enable set, and mixed cases where the operands take different sources, then a long sweep over a small register range so that matches are frequent.

// File: rtl/fwd_pkg.sv
// Package: shared encodings for the operand forwarding unit.
// Assumes a two-bit mux select per ALU operand in the execute stage.
package fwd_pkg;

    // Operand source select codes; the datapath mux decodes these bit positions.
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;

endpackage

// File: rtl/fwd_match.sv
// Module: fwd_match
// Flags that one older pipeline stage holds a result for one source register.
// Assumes register 0 is hard-wired and must never be treated as produced.
module fwd_match #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src_idx,
    input  logic [REG_AW-1:0] dst_idx,
    input  logic              wr_en,
    output logic              hit
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    // Purpose: compare producer destination against consumer source.
    always_comb begin
        hit = wr_en && (dst_idx != ZERO_REG) && (dst_idx == src_idx);
    end

endmodule

// File: rtl/fwd_operand_sel.sv
// Module: fwd_operand_sel
// Turns the two stage-match flags of one operand into a mux select.
// Assumes the execute/memory stage holds the younger of the two results.
module fwd_operand_sel
    import fwd_pkg::*;
(
    input  logic     mem_hit,
    input  logic     wb_hit,
    output fwd_sel_e sel
);

    // Purpose: prioritise the younger producer, then the older, then the file.
    always_comb begin
        if (mem_hit) begin
            sel = SEL_MEM;
        end else if (wb_hit) begin
            sel = SEL_WB;
        end else begin
            sel = SEL_RF;
        end
    end

endmodule

// File: rtl/fwd_unit.sv
// Module: fwd_unit (top)
// Chooses the source of both execute-stage ALU operands from the register
// file or one of the two later pipeline registers. Purely combinational.
// Assumes both later stages report a valid write enable each cycle.
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] ex_src_a_idx,
    input  logic [REG_AW-1:0] ex_src_b_idx,
    input  logic [REG_AW-1:0] mem_dst_idx,
    input  logic              mem_wr_en,
    input  logic [REG_AW-1:0] wb_dst_idx,
    input  logic              wb_wr_en,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b
);

    localparam int NUM_OPS = 2;

    logic [REG_AW-1:0] src_idx [NUM_OPS];
    fwd_sel_e          op_sel  [NUM_OPS];

    // Purpose: gather the operand source indices into an indexable array.
    always_comb begin
        src_idx[0] = ex_src_a_idx;
        src_idx[1] = ex_src_b_idx;
    end

    for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
        logic mem_hit;
        logic wb_hit;

        fwd_match #(.REG_AW(REG_AW)) mem_cmp_i (
            .src_idx (src_idx[op]),
            .dst_idx (mem_dst_idx),
            .wr_en   (mem_wr_en),
            .hit     (mem_hit)
        );

        fwd_match #(.REG_AW(REG_AW)) wb_cmp_i (
            .src_idx (src_idx[op]),
            .dst_idx (wb_dst_idx),
            .wr_en   (wb_wr_en),
            .hit     (wb_hit)
        );

        fwd_operand_sel sel_i (
            .mem_hit (mem_hit),
            .wb_hit  (wb_hit),
            .sel     (op_sel[op])
        );
    end

    // Purpose: drive the per-operand selects onto the output ports.
    always_comb begin
        sel_a = op_sel[0];
        sel_b = op_sel[1];
    end

endmodule

// File: rtl/fwd_unit_chk.sv
// Module: fwd_unit_chk
// Checks port-level forwarding rules whenever all inputs are known.
// Assumes it is bound to fwd_unit; uses immediate checks since the top has no clock.
module fwd_unit_chk #(
    parameter int REG_AW = 5
) (
    input logic [REG_AW-1:0] ex_src_a_idx,
    input logic [REG_AW-1:0] ex_src_b_idx,
    input logic [REG_AW-1:0] mem_dst_idx,
    input logic              mem_wr_en,
    input logic [REG_AW-1:0] wb_dst_idx,
    input logic              wb_wr_en,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b
);

    logic known;

    // Purpose: skip checks until every input and output is driven.
    always_comb begin
        known = !$isunknown({ex_src_a_idx, ex_src_b_idx, mem_dst_idx, mem_wr_en,
                             wb_dst_idx, wb_wr_en, sel_a, sel_b});
    end

    // Purpose: port-level forwarding properties.
    always_comb begin
        if (known) begin
            AST_SEL_A_LEGAL: assert (sel_a != 2'b11) else $error("sel_a illegal"); // R8
            AST_SEL_B_LEGAL: assert (sel_b != 2'b11) else $error("sel_b illegal"); // R8
            if (ex_src_a_idx == '0) begin
                AST_ZERO_SRC_A: assert (sel_a == 2'b00) else $error("zero fwd a"); // R6
            end
            if (ex_src_b_idx == '0) begin
                AST_ZERO_SRC_B: assert (sel_b == 2'b00) else $error("zero fwd b"); // R6
            end
            if (!mem_wr_en && !wb_wr_en) begin
                AST_NO_WRITE_NO_FWD: assert (sel_a == 2'b00 && sel_b == 2'b00)
                    else $error("fwd without write"); // R7
            end
            if (mem_wr_en && mem_dst_idx != '0 && mem_dst_idx == ex_src_a_idx) begin
                AST_MEM_WINS_A: assert (sel_a == 2'b10) else $error("mem a"); // R5
            end
            if (mem_wr_en && mem_dst_idx != '0 && mem_dst_idx == ex_src_b_idx) begin
                AST_MEM_WINS_B: assert (sel_b == 2'b10) else $error("mem b"); // R5
            end
            if (!mem_wr_en && wb_wr_en && wb_dst_idx != '0 && wb_dst_idx == ex_src_a_idx) begin
                AST_WB_FWD_A: assert (sel_a == 2'b01) else $error("wb a"); // R4
            end
        end
    end

endmodule

bind fwd_unit fwd_unit_chk #(.REG_AW(REG_AW)) chk_i (
    .ex_src_a_idx (ex_src_a_idx),
    .ex_src_b_idx (ex_src_b_idx),
    .mem_dst_idx  (mem_dst_idx),
    .mem_wr_en    (mem_wr_en),
    .wb_dst_idx   (wb_dst_idx),
    .wb_wr_en     (wb_wr_en),
    .sel_a        (sel_a),
    .sel_b        (sel_b)
);

// File: tb/fwd_unit_tb_top.sv
`timescale 1ns/1ps
// Bench: scoreboard for fwd_unit. The driver applies a vector at a rising
// edge and queues the expected selects; the monitor compares at the falling edge.
module fwd_unit_tb_top;

    localparam int REG_AW = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [REG_AW-1:0] src_a, src_b, mem_dst, wb_dst;
    logic              mem_we, wb_we;
    logic [1:0]        sel_a, sel_b;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    logic [1:0] exp_a_q [$];
    logic [1:0] exp_b_q [$];
    string      tag_q   [$];

    fwd_unit #(.REG_AW(REG_AW)) dut_i (
        .ex_src_a_idx (src_a),
        .ex_src_b_idx (src_b),
        .mem_dst_idx  (mem_dst),
        .mem_wr_en    (mem_we),
        .wb_dst_idx   (wb_dst),
        .wb_wr_en     (wb_we),
        .sel_a        (sel_a),
        .sel_b        (sel_b)
    );

    // Purpose: 125 MHz clock.
    always #4 clk = ~clk;

    // Purpose: expected select for one operand, from the requirement text.
    function automatic logic [1:0] model_sel(input logic [REG_AW-1:0] src);
        if (mem_we && mem_dst != 0 && mem_dst == src) return 2'b10;
        if (wb_we && wb_dst != 0 && wb_dst == src) return 2'b01;
        return 2'b00;
    endfunction

    // Purpose: drive one vector and queue its expected selects.
    task automatic drive(input logic [4:0] a, input logic [4:0] b,
                         input logic [4:0] md, input logic mw,
                         input logic [4:0] wd, input logic ww,
                         input logic [1:0] ea, input logic [1:0] eb,
                         input string tag);
        @(posedge clk);
        src_a = a; src_b = b; mem_dst = md; mem_we = mw; wb_dst = wd; wb_we = ww;
        exp_a_q.push_back(ea);
        exp_b_q.push_back(eb);
        tag_q.push_back(tag);
    endtask

    // Purpose: monitor pops and compares one item per falling edge.
    always @(negedge clk) begin
        if (tag_q.size() > 0) begin
            logic [1:0] ea, eb;
            string t;
            ea = exp_a_q.pop_front();
            eb = exp_b_q.pop_front();
            t  = tag_q.pop_front();
            checks++;
            if (sel_a !== ea || sel_b !== eb) begin
                errs++;
                $display("FAIL %s: sel_a=%b sel_b=%b expected %b %b", t, sel_a, sel_b, ea, eb);
            end
        end
    end

    // Purpose: watchdog ends a hung run as a failed check.
    initial begin
        #800000;
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    // Purpose: directed scenarios followed by a dense sweep.
    initial begin
        src_a = 0; src_b = 0; mem_dst = 0; mem_we = 0; wb_dst = 0; wb_we = 0;
        drive(0, 0, 0, 0, 0, 0, 2'b00, 2'b00, "R1 reset state");
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        drive(3, 4, 7, 1, 8, 1, 2'b00, 2'b00, "R1 no match");
        drive(5, 6, 5, 1, 9, 0, 2'b10, 2'b00, "R2 mem to A");
        drive(5, 6, 6, 1, 9, 0, 2'b00, 2'b10, "R3 mem to B");
        drive(5, 6, 1, 0, 5, 1, 2'b01, 2'b00, "R4 wb to A");
        drive(5, 6, 1, 0, 6, 1, 2'b00, 2'b01, "R4 wb to B");
        drive(7, 2, 7, 1, 7, 1, 2'b10, 2'b00, "R5 both stages same reg");
        drive(2, 7, 7, 1, 7, 1, 2'b00, 2'b10, "R5 both stages B");
        drive(0, 0, 0, 1, 0, 1, 2'b00, 2'b00, "R6 zero dest and src");
        drive(3, 0, 0, 1, 3, 1, 2'b01, 2'b00, "R6 zero mem dest falls to wb");
        drive(9, 9, 9, 0, 9, 0, 2'b00, 2'b00, "R7 write enables low");
        drive(9, 4, 9, 0, 4, 0, 2'b00, 2'b00, "R7 disabled both ops");
        drive(9, 4, 9, 1, 4, 1, 2'b10, 2'b01, "R9 mixed sources");
        drive(12, 12, 12, 1, 3, 1, 2'b10, 2'b10, "R9 same reg both ops");
        drive(12, 12, 1, 1, 12, 1, 2'b01, 2'b01, "R9 same reg wb both ops");
        // R10: result compared in the same cycle its vector is applied
        drive(31, 30, 31, 1, 30, 1, 2'b10, 2'b01, "R10 same-cycle response");
        for (int i = 0; i < 300; i++) begin
            logic [4:0] a, b, md, wd;
            logic mw, ww;
            a  = 5'($urandom_range(0, 3));
            b  = 5'($urandom_range(0, 3));
            md = 5'($urandom_range(0, 3));
            wd = 5'($urandom_range(0, 3));
            mw = 1'($urandom_range(0, 1));
            ww = 1'($urandom_range(0, 1));
            @(posedge clk);
            src_a = a; src_b = b; mem_dst = md; mem_we = mw; wb_dst = wd; wb_we = ww;
            exp_a_q.push_back(model_sel(a));
            exp_b_q.push_back(model_sel(b));
            tag_q.push_back("R8 sweep");
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule